// File: doc/BRIEF.md
# NAND ECC Syndrome Checker

This block judges the integrity of a NAND data chunk once its error-correcting code has been recomputed. For each 256-byte chunk it takes two 22-bit codes: the one just computed over the data read back, and the one read from the spare area. Each code is two 11-bit lanes. The lower lane comes from the first 11-bit code register and the upper lane from the second. When the codes sit in the spare area they take three bytes per chunk, least significant byte first. The block XORs the two codes to form a syndrome. It then sorts the chunk into one of four outcomes: clean, a damaged code field, a single flipped data bit that can be repaired, or damage that cannot be repaired. For the repairable case it reports which byte and which bit within that byte to invert, so the controller can patch its buffer.

A 512-byte page is treated as two independent 256-byte halves. The second half uses the next code pair. The two failure indications are ORed into one flag, and byte locations in the second half are offset by 256. A mode input chooses between one-half and two-half operation. The check runs over two pipelined stages, and a one-cycle completion pulse follows one cycle after the results are registered.

Top module: `ecc_syndrome_checker`

## Requirements
- R1: A half whose syndrome is zero, or whose computed or stored code is all zeros, reports status 0 (clean) with no fix and no failure, even when its syndrome has a single bit set.
- R2: A half whose syndrome has exactly one bit set (and whose codes are both non-zero) reports status 1 (code field damaged), raises no fix, and counts as a failure.
- R3: A half whose syndrome has exactly 11 bits set, and whose lower lane XOR upper lane equals 11'h7FF, reports status 2 (repairable). Its fix_valid bit is set, its bit location is syndrome bits 2:0 and its byte location is syndrome bits 10:3. It is not a failure.
- R4: Any other non-zero syndrome, including an 11-bit syndrome whose lanes are not complementary, reports status 3 (unrepairable) and counts as a failure.
- R5: With wide_page high, the second half is judged on code bits 43:22 by the same rules, and its byte location carries an offset of 256.
- R6: With wide_page low, the second half's codes are ignored: its status is 0, its fix_valid is 0, and it never sets fail.
- R7: fail is the OR of the failure outcomes (status 1 or 3) of all active halves.
- R8: The status, fix_valid, fix_byte and fix_bit outputs are registered two clock edges after in_valid is sampled. fail and a one-cycle done pulse follow on the third edge. All outputs hold until the next request.
- R9: After reset, done, fail, every status field, every fix_valid bit and every location are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; codes and mode are sampled when high |
| wide_page | input | 1 | 1: two halves (512-byte page); 0: first half only |
| calc_codes | input | 44 | Computed codes, half h at bits 22h+21:22h |
| stored_codes | input | 44 | Stored codes, same packing |
| status | output | 4 | Outcome of half h at bits 2h+1:2h (0 clean, 1 code field, 2 repairable, 3 unrepairable) |
| fix_valid | output | 2 | Bit h set when half h holds a repairable error |
| fix_byte | output | 18 | Failing byte index of half h at bits 9h+8:9h, 0..511 |
| fix_bit | output | 6 | Failing bit index of half h at bits 3h+2:3h |
| fail | output | 1 | OR of failure outcomes across active halves |
| done | output | 1 | One-cycle pulse marking results ready |

## Verification
The bench sweeps every one of the 2048 repairable locations in each half. An off-by-one in the lane split or a missing 256 offset would therefore report a wrong byte or bit at some location. All 22 single-bit syndromes and all 231 two-bit syndromes are applied, along with 11-bit syndromes whose lanes are not complementary. A design that relied on the popcount alone would call those repairable and hide real damage. Zero-code cases where the syndrome has a single bit set are also applied, and a design that tested the bit count before the zero rule would report a damaged field there. Narrow-mode runs put damaging codes on the second half, and the bench checks that a design which failed to mask that half raises neither fail nor a status. Latency is checked on every request, together with hold behaviour between requests.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN    = 2'd0,
      ST_CODE_HIT = 2'd1,
      ST_FIXABLE  = 2'd2,
      ST_BROKEN   = 2'd3
   } ecc_verdict_e;

   function automatic int unsigned ones_count(input logic [63:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 64; i++) begin
         n += int'(v[i]);
      end
      return n;
   endfunction

endpackage

// File: rtl/ecc_syn_front.sv
module ecc_syn_front #(
   parameter int LANE_W = 11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  active,
   input  logic [2*LANE_W-1:0]   calc_code,
   input  logic [2*LANE_W-1:0]   stored_code,
   output logic                  s1_valid,
   output logic [2*LANE_W-1:0]   s1_syn,
   output logic                  s1_skip,
   output logic                  s1_pair
);
   localparam int CODE_W = 2 * LANE_W;

   logic [CODE_W-1:0] syn_d;
   logic              skip_d;
   logic              pair_d;

   assign syn_d  = calc_code ^ stored_code;
   assign skip_d = !active || (calc_code == '0) || (stored_code == '0);
   assign pair_d = ((syn_d[LANE_W-1:0] ^ syn_d[CODE_W-1:LANE_W]) == '1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_syn   <= '0;
         s1_skip  <= 1'b0;
         s1_pair  <= 1'b0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_syn  <= syn_d;
            s1_skip <= skip_d;
            s1_pair <= pair_d;
         end
      end
   end

   // R6: an inactive half is always marked to skip
   a_r6_inactive_skip: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !active |=> s1_skip);

endmodule

// File: rtl/ecc_syn_judge.sv
module ecc_syn_judge
   import ecc_syn_pkg::*;
#(
   parameter int LANE_W   = 11,
   parameter int IDX_W    = 9,
   parameter int HALF_IDX = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  s1_valid,
   input  logic [2*LANE_W-1:0]   s1_syn,
   input  logic                  s1_skip,
   input  logic                  s1_pair,
   output logic                  r_valid,
   output logic [1:0]            status_o,
   output logic                  fix_valid_o,
   output logic [IDX_W-1:0]      fix_byte_o,
   output logic [2:0]            fix_bit_o,
   output logic                  flag_o
);
   localparam int CODE_W = 2 * LANE_W;
   localparam int POS_W  = LANE_W - 3;

   int unsigned  ones;
   ecc_verdict_e verdict_d;
   logic [IDX_W-1:0] byte_d;

   assign ones   = ones_count(64'(s1_syn));
   assign byte_d = (IDX_W'(HALF_IDX) << POS_W) | IDX_W'(s1_syn[LANE_W-1:3]);

   always_comb begin
      if (s1_skip || (s1_syn == '0)) begin
         verdict_d = ST_CLEAN;
      end else if (ones == 1) begin
         verdict_d = ST_CODE_HIT;
      end else if ((ones == LANE_W) && s1_pair) begin
         verdict_d = ST_FIXABLE;
      end else begin
         verdict_d = ST_BROKEN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_valid     <= 1'b0;
         status_o    <= ST_CLEAN;
         fix_valid_o <= 1'b0;
         fix_byte_o  <= '0;
         fix_bit_o   <= '0;
         flag_o      <= 1'b0;
      end else begin
         r_valid <= s1_valid;
         if (s1_valid) begin
            status_o    <= verdict_d;
            fix_valid_o <= (verdict_d == ST_FIXABLE);
            fix_byte_o  <= (verdict_d == ST_FIXABLE) ? byte_d : '0;
            fix_bit_o   <= (verdict_d == ST_FIXABLE) ? s1_syn[2:0] : 3'd0;
            flag_o      <= (verdict_d == ST_CODE_HIT) || (verdict_d == ST_BROKEN);
         end
      end
   end

   // R1: an all-zero syndrome always yields a clean outcome
   a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && (s1_syn == '0) |=> (status_o == ST_CLEAN) && !flag_o);

   // R2: a lone syndrome bit on live codes marks the code field
   a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && !s1_skip && ($countones(s1_syn) == 1)
      |=> (status_o == ST_CODE_HIT) && !fix_valid_o && flag_o);

   // R3: a reported fix points at the low lane of the syndrome
   a_r3_fix_location: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid && fix_valid_o |-> (fix_bit_o == $past(s1_syn[2:0])) && !flag_o);

   // R4: lanes that are not complementary can never be repaired
   a_r4_no_false_fix: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid && !s1_pair |=> !fix_valid_o);

endmodule

// File: rtl/ecc_syn_merge.sv
module ecc_syn_merge #(
   parameter int NUM_HALVES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_HALVES-1:0] half_rdy,
   input  logic [NUM_HALVES-1:0] half_flag,
   output logic                  fail,
   output logic                  done
);
   logic all_rdy;
   assign all_rdy = &half_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fail <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= all_rdy;
         if (all_rdy) begin
            fail <= |half_flag;
         end
      end
   end

   // R8: every result stage runs in lock step
   a_r8_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      (half_rdy == '0) || (half_rdy == '1));

endmodule

// File: rtl/ecc_syndrome_checker.sv
module ecc_syndrome_checker #(
   parameter int LANE_W     = 11,
   parameter int NUM_HALVES = 2
) (
   input  logic                                                   clk,
   input  logic                                                   rst_n,
   input  logic                                                   in_valid,
   input  logic                                                   wide_page,
   input  logic [NUM_HALVES*2*LANE_W-1:0]                         calc_codes,
   input  logic [NUM_HALVES*2*LANE_W-1:0]                         stored_codes,
   output logic [NUM_HALVES*2-1:0]                                status,
   output logic [NUM_HALVES-1:0]                                  fix_valid,
   output logic [NUM_HALVES*(LANE_W-3+$clog2(NUM_HALVES))-1:0]    fix_byte,
   output logic [NUM_HALVES*3-1:0]                                fix_bit,
   output logic                                                   fail,
   output logic                                                   done
);
   localparam int CODE_W = 2 * LANE_W;
   localparam int POS_W  = LANE_W - 3;
   localparam int HALF_W = $clog2(NUM_HALVES);
   localparam int IDX_W  = POS_W + HALF_W;

   if ((LANE_W < 4) || (LANE_W > 31)) begin : g_bad_lane
      $error("LANE_W must lie between 4 and 31");
   end
   if (NUM_HALVES < 1) begin : g_bad_halves
      $error("NUM_HALVES must be at least 1");
   end

   logic [NUM_HALVES-1:0] half_rdy;
   logic [NUM_HALVES-1:0] half_flag;

   for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      logic              act;
      logic              s1_valid;
      logic [CODE_W-1:0] s1_syn;
      logic              s1_skip;
      logic              s1_pair;

      assign act = (h == 0) || wide_page;

      ecc_syn_front #(.LANE_W(LANE_W)) u_front (
         .clk         (clk),
         .rst_n       (rst_n),
         .in_valid    (in_valid),
         .active      (act),
         .calc_code   (calc_codes[h*CODE_W +: CODE_W]),
         .stored_code (stored_codes[h*CODE_W +: CODE_W]),
         .s1_valid    (s1_valid),
         .s1_syn      (s1_syn),
         .s1_skip     (s1_skip),
         .s1_pair     (s1_pair)
      );

      ecc_syn_judge #(.LANE_W(LANE_W), .IDX_W(IDX_W), .HALF_IDX(h)) u_judge (
         .clk         (clk),
         .rst_n       (rst_n),
         .s1_valid    (s1_valid),
         .s1_syn      (s1_syn),
         .s1_skip     (s1_skip),
         .s1_pair     (s1_pair),
         .r_valid     (half_rdy[h]),
         .status_o    (status[2*h +: 2]),
         .fix_valid_o (fix_valid[h]),
         .fix_byte_o  (fix_byte[h*IDX_W +: IDX_W]),
         .fix_bit_o   (fix_bit[3*h +: 3]),
         .flag_o      (half_flag[h])
      );
   end

   ecc_syn_merge #(.NUM_HALVES(NUM_HALVES)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_rdy  (half_rdy),
      .half_flag (half_flag),
      .fail      (fail),
      .done      (done)
   );

   logic any_bad;
   always_comb begin
      any_bad = 1'b0;
      for (int h = 0; h < NUM_HALVES; h++) begin
         if ((status[2*h +: 2] == 2'd1) || (status[2*h +: 2] == 2'd3)) begin
            any_bad = 1'b1;
         end
      end
   end

   // R8: done follows the request on the third edge
   a_r8_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##3 done);

   // R7: the merged flag agrees with the per-half outcomes it summarises
   a_r7_fail_track: assert property (@(posedge clk) disable iff (!rst_n)
      done && !$past(in_valid, 2) |-> (fail == any_bad));

endmodule

// File: tb/ecc_syndrome_checker_tb.sv
`timescale 1ns/1ps
module ecc_syndrome_checker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        wide_page = 1'b0;
   logic [43:0] calc_codes = '0;
   logic [43:0] stored_codes = '0;
   logic [3:0]  status;
   logic [1:0]  fix_valid;
   logic [17:0] fix_byte;
   logic [5:0]  fix_bit;
   logic        fail;
   logic        done;

   int tests = 0;
   int fails = 0;

   always #2 clk = ~clk;

   ecc_syndrome_checker u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .wide_page    (wide_page),
      .calc_codes   (calc_codes),
      .stored_codes (stored_codes),
      .status       (status),
      .fix_valid    (fix_valid),
      .fix_byte     (fix_byte),
      .fix_bit      (fix_bit),
      .fail         (fail),
      .done         (done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Expected outcome from the classification rules (R1..R4)
   function automatic int model(input logic [21:0] c, input logic [21:0] s);
      logic [21:0] y;
      int n;
      y = c ^ s;
      n = $countones(y);
      if ((y == 0) || (c == 0) || (s == 0)) return 0;
      if (n == 1) return 1;
      if ((n == 11) && ((y[10:0] ^ y[21:11]) == 11'h7FF)) return 2;
      return 3;
   endfunction

   // Issue one request and sample after done; checks latency (R8)
   task automatic run_op(input logic wide, input logic [21:0] c0, input logic [21:0] s0,
                         input logic [21:0] c1, input logic [21:0] s1);
      @(negedge clk);
      in_valid     = 1'b1;
      wide_page    = wide;
      calc_codes   = {c1, c0};
      stored_codes = {s1, s0};
      @(negedge clk);
      in_valid     = 1'b0;
      calc_codes   = '0;
      stored_codes = '0;
      @(negedge clk);
      chk("R8 done early", int'(done), 0);
      @(negedge clk);
      chk("R8 done on time", int'(done), 1);
   endtask

   function automatic logic [21:0] fix_syn(input int pos);
      logic [10:0] p;
      p = pos[10:0];
      return {~p, p};
   endfunction

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [21:0] st;
      logic [21:0] y;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 done", int'(done), 0);
      chk("R9 fail", int'(fail), 0);
      chk("R9 status", int'(status), 0);
      chk("R9 fix_valid", int'(fix_valid), 0);
      chk("R9 fix_byte", int'(fix_byte), 0);

      // R3 + R6: all repairable locations in half 0, narrow mode with a damaged half 1
      for (int pos = 0; pos < 2048; pos++) begin
         st = {pos[10:0] ^ 11'h2A5, 11'h3C3};
         run_op(1'b0, st ^ fix_syn(pos), st, 22'h000001, 22'h000003);
         chk("R3 status", int'(status[1:0]), 2);
         chk("R3 fix_valid", int'(fix_valid[0]), 1);
         chk("R3 byte", int'(fix_byte[8:0]), pos / 8);
         chk("R3 bit", int'(fix_bit[2:0]), pos % 8);
         chk("R7 fail", int'(fail), 0);
         chk("R6 status1", int'(status[3:2]), 0);
         chk("R6 fix_valid1", int'(fix_valid[1]), 0);
      end

      // R5: all repairable locations in half 1, wide mode
      for (int pos = 0; pos < 2048; pos++) begin
         st = {11'h1F0 ^ pos[10:0], 11'h0A9};
         run_op(1'b1, 22'h012345, 22'h012345, st ^ fix_syn(pos), st);
         chk("R5 status0", int'(status[1:0]), 0);
         chk("R5 status1", int'(status[3:2]), 2);
         chk("R5 byte", int'(fix_byte[17:9]), 256 + pos / 8);
         chk("R5 bit", int'(fix_bit[5:3]), pos % 8);
         chk("R5 fail", int'(fail), 0);
      end

      // R2: every single-bit syndrome
      for (int i = 0; i < 22; i++) begin
         y = 22'(1) << i;
         run_op(1'b0, 22'h2AAAAA ^ y, 22'h2AAAAA, 22'h0, 22'h0);
         chk("R2 status", int'(status[1:0]), 1);
         chk("R2 fix_valid", int'(fix_valid[0]), 0);
         chk("R2 fail", int'(fail), 1);
      end

      // R4: every two-bit syndrome
      for (int i = 0; i < 22; i++) begin
         for (int j = i + 1; j < 22; j++) begin
            y = (22'(1) << i) | (22'(1) << j);
            run_op(1'b0, 22'h15A5A5 ^ y, 22'h15A5A5, 22'h0, 22'h0);
            chk("R4 status", int'(status[1:0]), 3);
            chk("R4 fail", int'(fail), 1);
         end
      end

      // R4: eleven bits set but lanes not complementary
      for (int k = 0; k < 11; k++) begin
         y = {11'(1) << ((k + 1) % 11), 11'h7FF ^ (11'(1) << k)};
         run_op(1'b0, 22'h3C3C3C ^ y, 22'h3C3C3C, 22'h0, 22'h0);
         chk("R4 status popcount-only", int'(status[1:0]), model(22'h3C3C3C ^ y, 22'h3C3C3C));
         chk("R4 status11", int'(status[1:0]), 3);
         chk("R4 fix_valid11", int'(fix_valid[0]), 0);
         chk("R4 fail11", int'(fail), 1);
      end

      // R1: clean and zero-code cases
      run_op(1'b0, 22'h1ABCDE, 22'h1ABCDE, 22'h0, 22'h0);
      chk("R1 equal codes", int'(status[1:0]), 0);
      chk("R1 equal fail", int'(fail), 0);
      run_op(1'b0, 22'h000000, 22'h000400, 22'h0, 22'h0);
      chk("R1 zero calc", int'(status[1:0]), 0);
      chk("R1 zero calc fail", int'(fail), 0);
      run_op(1'b0, fix_syn(77), 22'h000000, 22'h0, 22'h0);
      chk("R1 zero stored", int'(status[1:0]), 0);
      chk("R1 zero stored fix", int'(fix_valid[0]), 0);
      run_op(1'b1, 22'h0, 22'h0, 22'h0, 22'h0);
      chk("R1 both zero", int'(status), 0);

      // R7: merging across halves in wide mode
      run_op(1'b1, 22'h2AAAAA ^ 22'h000010, 22'h2AAAAA, 22'h0F0F0F, 22'h0F0F0F);
      chk("R7 code hit half0", int'(status), 1);
      chk("R7 fail half0", int'(fail), 1);
      run_op(1'b1, 22'h0F0F0F, 22'h0F0F0F, 22'h15A5A5 ^ 22'h000003, 22'h15A5A5);
      chk("R7 broken half1", int'(status[3:2]), 3);
      chk("R7 fail half1", int'(fail), 1);
      run_op(1'b1, 22'h3FFFFF ^ fix_syn(5), 22'h3FFFFF, 22'h3FFFFF ^ fix_syn(2047), 22'h3FFFFF);
      chk("R7 two fixes", int'(fix_valid), 3);
      chk("R7 two fixes byte0", int'(fix_byte[8:0]), 0);
      chk("R7 two fixes byte1", int'(fix_byte[17:9]), 511);
      chk("R7 two fixes bit1", int'(fix_bit[5:3]), 7);
      chk("R7 two fixes fail", int'(fail), 0);

      // R8: outputs hold and done stays low between requests
      repeat (3) @(negedge clk);
      chk("R8 hold done", int'(done), 0);
      chk("R8 hold fix", int'(fix_valid), 3);
      chk("R8 hold byte1", int'(fix_byte[17:9]), 511);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule